// File: doc/BRIEF.md
# Card-Slot Control Registers

This block is a small set of board control registers that sits beside a memory-card slot. A register-bus master reads it and writes it through a word-addressed port with a combinational read path. The block returns two fixed identification and decode words. It shows the slot's write-protect switch as a live status bit. It captures card-insertion events in a sticky status bit, and that bit drives the card interrupt line.

The two status bits share one word but follow different policies. The write-protect bit simply follows its input pin. The insertion bit is kept by a two-state machine with the states `CS_EMPTY` and `CS_LATCHED`:
- The transition `set` goes from `CS_EMPTY` to `CS_LATCHED`. It is taken on any clock edge where the card-insert input is high.
- The transition `clear` goes from `CS_LATCHED` to `CS_EMPTY`. It is taken only on a write-one-to-clear write to the status word while the input is low.
- In every other case the state holds.

Writes to the programming-control word and the decode word are accepted and have no effect.

Top module: `cslot_ctrl_regs`

## Requirements
- R1: Word address 0 reads 0x41034003, word address 1 reads 0x00000000 and word address 3 reads 0x00000011.
- R2: Bit 0 of the status word (word address 2) equals the write-protect input in the same cycle, with no clock edge needed.
- R3: When the card-insert input is high at a rising clock edge, status bit 3 reads 1 and the interrupt output is high from that edge on.
- R4: When the card-insert input falls, neither status bit 3 nor the interrupt output is cleared.
- R5: A write to word address 2 whose data has bit 3 set clears status bit 3 at that edge, and the interrupt output then equals bit 3. A write to word 2 with data bit 3 at 0 changes nothing, and status bit 0 cannot be written.
- R6: If the card-insert input is high during a clearing write, the set wins and status bit 3 stays 1.
- R7: Writes to word addresses 1 and 3 leave every read value and the interrupt output unchanged.
- R8: An active-low asynchronous reset clears status bit 3 and drops the interrupt output, and both stay low while reset is held.
- R9: Word addresses other than 0 to 3 read as zero, and writes to them have no effect. Status bits other than 0 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr (combinational) |
| wp_i | input | 1 | Write-protect switch level |
| card_i | input | 1 | Card-insert event input |
| irq_o | output | 1 | Card interrupt, equal to status bit 3 |

## Verification
The bench builds the block with its default parameters. These are a 32-bit data word, a 4-bit word address, write-protect at bit 0 and insertion at bit 3. The 4-bit address gives twelve unmapped word addresses, so reads and writes outside the four decoded words can be exercised. Placing the two status bits at separate positions lets a write of all ones to the status word show that only the sticky bit responds and the live bit cannot be written. Holding the insert input high on the same edge as a clearing write brings the set-over-clear priority within reach.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

    // Sticky card-insertion latch states
    typedef enum logic [0:0] {
        CS_EMPTY   = 1'b0,
        CS_LATCHED = 1'b1
    } latch_state_e;

    // Decoded word addresses; the bus master relies on these positions
    localparam int unsigned WORD_IDENT  = 0;
    localparam int unsigned WORD_PROG   = 1;
    localparam int unsigned WORD_STATUS = 2;
    localparam int unsigned WORD_DECODE = 3;

endpackage

// File: rtl/cslot_write_decode.sv
module cslot_write_decode
    import cslot_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              clr_bit,
    output logic              card_clr
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(WORD_STATUS);

    // Only the status word carries a write side effect. Writes to the
    // programming word, the decode word and unmapped words fall through.
    always_comb begin
        card_clr = 1'b0;
        if (bus_wr && (bus_addr == STATUS_ADDR)) begin
            card_clr = clr_bit;
        end
    end

endmodule

// File: rtl/cslot_latch_fsm.sv
module cslot_latch_fsm
    import cslot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic card_i,
    input  logic card_clr,
    output logic latched,
    output logic irq_o
);

    latch_state_e state_q;
    latch_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: set has priority over clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_EMPTY: begin
                if (card_i) begin
                    state_d = CS_LATCHED;
                end
            end
            CS_LATCHED: begin
                if (card_clr && !card_i) begin
                    state_d = CS_EMPTY;
                end
            end
            default: state_d = CS_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        latched = 1'b0;
        irq_o   = 1'b0;
        unique case (state_q)
            CS_EMPTY: begin
                latched = 1'b0;
                irq_o   = 1'b0;
            end
            CS_LATCHED: begin
                latched = 1'b1;
                irq_o   = 1'b1;
            end
            default: begin
                latched = 1'b0;
                irq_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cslot_read_mux.sv
module cslot_read_mux
    import cslot_pkg::*;
#(
    parameter int unsigned          ADDR_W       = 4,
    parameter int unsigned          DATA_W       = 32,
    parameter logic [DATA_W-1:0]    ID_VALUE     = 32'h4103_4003,
    parameter logic [DATA_W-1:0]    DECODE_VALUE = 32'h0000_0011,
    parameter int unsigned          WP_BIT       = 0,
    parameter int unsigned          CARD_BIT     = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wp_i,
    input  logic              latched,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] IDENT_ADDR  = ADDR_W'(WORD_IDENT);
    localparam logic [ADDR_W-1:0] PROG_ADDR   = ADDR_W'(WORD_PROG);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(WORD_STATUS);
    localparam logic [ADDR_W-1:0] DECODE_ADDR = ADDR_W'(WORD_DECODE);

    logic [DATA_W-1:0] status_word;

    // Assemble the status word bit by bit from the two bit positions
    for (genvar b = 0; b < DATA_W; b++) begin : g_status
        if (b == WP_BIT) begin : g_wp
            assign status_word[b] = wp_i;
        end else if (b == CARD_BIT) begin : g_card
            assign status_word[b] = latched;
        end else begin : g_zero
            assign status_word[b] = 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            IDENT_ADDR:  bus_rdata = ID_VALUE;
            PROG_ADDR:   bus_rdata = '0;
            STATUS_ADDR: bus_rdata = status_word;
            DECODE_ADDR: bus_rdata = DECODE_VALUE;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cslot_ctrl_regs.sv
module cslot_ctrl_regs
    import cslot_pkg::*;
#(
    parameter int unsigned          ADDR_W       = 4,
    parameter int unsigned          DATA_W       = 32,
    parameter logic [DATA_W-1:0]    ID_VALUE     = 32'h4103_4003,
    parameter logic [DATA_W-1:0]    DECODE_VALUE = 32'h0000_0011,
    parameter int unsigned          WP_BIT       = 0,
    parameter int unsigned          CARD_BIT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wp_i,
    input  logic              card_i,
    output logic              irq_o
);

    logic card_clr;
    logic latched;

    cslot_write_decode #(
        .ADDR_W (ADDR_W)
    ) u_wdec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .clr_bit  (bus_wdata[CARD_BIT]),
        .card_clr (card_clr)
    );

    cslot_latch_fsm u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_i   (card_i),
        .card_clr (card_clr),
        .latched  (latched),
        .irq_o    (irq_o)
    );

    cslot_read_mux #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .ID_VALUE     (ID_VALUE),
        .DECODE_VALUE (DECODE_VALUE),
        .WP_BIT       (WP_BIT),
        .CARD_BIT     (CARD_BIT)
    ) u_rmux (
        .bus_addr  (bus_addr),
        .wp_i      (wp_i),
        .latched   (latched),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/cslot_ctrl_checker.sv
module cslot_ctrl_checker
    import cslot_pkg::*;
#(
    parameter int unsigned          ADDR_W       = 4,
    parameter int unsigned          DATA_W       = 32,
    parameter logic [DATA_W-1:0]    ID_VALUE     = 32'h4103_4003,
    parameter logic [DATA_W-1:0]    DECODE_VALUE = 32'h0000_0011,
    parameter int unsigned          WP_BIT       = 0,
    parameter int unsigned          CARD_BIT     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wp_i,
    input logic              card_i,
    input logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(WORD_IDENT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WORD_STATUS);
    localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(WORD_DECODE);

    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == A_STATUS) && bus_wdata[CARD_BIT];

    // R1: identification and decode constants
    a_r1_ident_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_IDENT) |-> (bus_rdata == ID_VALUE));
    a_r1_decode_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DECODE) |-> (bus_rdata == DECODE_VALUE));

    // R2: live write-protect mirror
    a_r2_wp_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |-> (bus_rdata[WP_BIT] == wp_i));

    // R5: interrupt equals the sticky status bit
    a_r5_irq_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |-> (bus_rdata[CARD_BIT] == irq_o));

    // R3: insertion sets the latch
    a_r3_insert_sets: assert property (@(posedge clk) disable iff (!rst_n)
        card_i |=> irq_o);

    // R4: the latch holds without a clearing write
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_wr) |=> irq_o);

    // R5: a clearing write with the input low releases the latch
    a_r5_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !card_i) |=> !irq_o);

    // R6: set wins over a simultaneous clear
    a_r6_set_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && card_i) |=> irq_o);

    // R7 and R9: writes to any word other than status leave the interrupt alone
    a_r7_other_writes_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr != A_STATUS) && !card_i && (bus_wdata != '0))
        |=> $stable(irq_o));

endmodule

bind cslot_ctrl_regs cslot_ctrl_checker #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .ID_VALUE     (ID_VALUE),
    .DECODE_VALUE (DECODE_VALUE),
    .WP_BIT       (WP_BIT),
    .CARD_BIT     (CARD_BIT)
) u_cslot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wp_i      (wp_i),
    .card_i    (card_i),
    .irq_o     (irq_o)
);

// File: tb/test_cslot_ctrl_regs.sv
module test_cslot_ctrl_regs;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              wp_i = 1'b0;
    logic              card_i = 1'b0;
    logic              irq_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    cslot_ctrl_regs i_cslot_ctrl_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wp_i      (wp_i),
        .card_i    (card_i),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  addr;
        logic        wr;
        logic [31:0] wdata;
        logic        wp;
        logic        card;
        logic [31:0] exp_stat;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd8, 4'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 1'b0}, // R8 idle after reset
        '{4'd2, 4'd0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h1, 1'b0}, // R2 wp high
        '{4'd3, 4'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h8, 1'b1}, // R3 insertion
        '{4'd4, 4'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h8, 1'b1}, // R4 input fell
        '{4'd5, 4'd2, 1'b1, 32'h0000_0001, 1'b0, 1'b0, 32'h8, 1'b1}, // R5 bit3 zero, bit0 not writable
        '{4'd6, 4'd2, 1'b1, 32'h0000_0008, 1'b0, 1'b1, 32'h8, 1'b1}, // R6 set beats clear
        '{4'd5, 4'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1, 1'b0}, // R5 clear
        '{4'd3, 4'd0, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 32'h9, 1'b1}, // R3 re-latch
        '{4'd7, 4'd1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h9, 1'b1}, // R7 prog word write
        '{4'd7, 4'd3, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h9, 1'b1}, // R7 decode word write
        '{4'd9, 4'd9, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h9, 1'b1}, // R9 unmapped write
        '{4'd5, 4'd2, 1'b1, 32'h0000_0008, 1'b1, 1'b0, 32'h1, 1'b0}, // R5 exact clear bit
        '{4'd2, 4'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 1'b0}  // R2 wp low
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic read_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic apply(input vec_t v, input int idx);
        @(negedge clk);
        bus_addr  = v.addr;
        bus_wr    = v.wr;
        bus_wdata = v.wdata;
        wp_i      = v.wp;
        card_i    = v.card;
        @(posedge clk);
        #2;
        bus_wr   = 1'b0;
        bus_addr = 4'd2;
        #3;
        check($sformatf("R%0d vec%0d status", v.req, idx), bus_rdata, v.exp_stat);
        check($sformatf("R%0d vec%0d irq", v.req, idx), {31'b0, irq_o}, {31'b0, v.exp_irq});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R8 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R8: held in reset
        repeat (3) @(posedge clk);
        #5;
        bus_addr = 4'd2;
        card_i = 1'b1;
        #1;
        check("R8 status in reset", bus_rdata, 32'h0);
        check("R8 irq in reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        card_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 constants, R9 unmapped reads
        read_check("R1 word0", 4'd0, 32'h4103_4003);
        read_check("R1 word1", 4'd1, 32'h0);
        read_check("R1 word3", 4'd3, 32'h0000_0011);
        read_check("R9 word5", 4'd5, 32'h0);
        read_check("R9 word15", 4'd15, 32'h0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], i);
        end

        // R7: constant words unchanged after the writes
        read_check("R7 word1 after write", 4'd1, 32'h0);
        read_check("R7 word3 after write", 4'd3, 32'h0000_0011);

        // R2: write-protect seen without a clock edge
        @(negedge clk);
        bus_addr = 4'd2;
        wp_i = 1'b1;
        #1;
        check("R2 live wp high", bus_rdata, 32'h1);
        wp_i = 1'b0;
        #1;
        check("R2 live wp low", bus_rdata, 32'h0);

        // R8: asynchronous reset drops a latched interrupt
        @(negedge clk);
        card_i = 1'b1;
        @(posedge clk);
        #5;
        check("R8 latched before reset", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        card_i = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R8 irq after async reset", {31'b0, irq_o}, 32'h0);
        check("R8 status after async reset", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R8 stays clear after release", {31'b0, irq_o}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule